// File: doc/BRIEF.md
# UART Interrupt Identifier with Receive Trigger

This block sits beside a UART's receive and transmit FIFOs. It turns their status into one prioritized interrupt identification code and an interrupt request line. It watches the receive FIFO occupancy against a programmable fill threshold and counts character times to detect a stalled receive FIFO. It also tracks the transmit-holding-empty event until software acknowledges it. The FIFOs, the serializer and the bus decode are outside the block. The block sees register writes and reads only as strobes with their data.

The FIFO depth is a parameter and may be 16 or 64. A two-bit trigger selector picks one of four thresholds from a table that depends on that depth. Software enables each interrupt source separately. The identification byte carries the 4-bit code in bits 3:0 and a FIFO-mode flag in bit 7.

Top module: `uart_irq_ident`

## Requirements
- R1: `ident_byte[3:0]` encodes the reported source: 0x1 none, 0x6 line status, 0x4 data ready, 0xC character timeout, 0x2 transmit holding empty. Bits 6:4 read 0.
- R2: An `ier_we` strobe loads `ier_wdata`. Bit 0 enables data ready and timeout, bit 1 enables transmit holding empty, and bit 2 enables line status. A disabled source is neither reported nor drives `irq`.
- R3: Only the highest enabled pending source is reported. The order is line status, then data ready, then character timeout, then transmit holding empty.
- R4: With a depth of 16 and FIFO mode on, trigger selector values 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 characters.
- R5: With a depth of 64 and FIFO mode on, trigger selector values 0, 1, 2 and 3 give thresholds of 1, 16, 48 and 56 characters.
- R6: An `fcr_we` strobe loads the FIFO-mode enable and the trigger selector. `ident_byte[7]` and `fifo_mode` equal the stored enable. With FIFO mode off, the threshold is 1 and the timeout source never asserts.
- R7: Data ready is pending in the same cycle that `rx_count` is at or above the threshold. It stops being pending in the same cycle that `rx_count` falls below it.
- R8: The timeout source asserts when FIFO mode is on and `rx_count` is nonzero, and `char_tick` has been sampled high on 4 clock edges with no `rx_push` or `rx_pop` in between. An `rx_pop` or `rx_push` restarts the count and clears the source.
- R9: The transmit-holding-empty source is set on a rising edge of `thr_empty`. It is cleared by `tx_write`, or by `iid_rd` while 0x2 is the reported code. A clear wins over a set in the same cycle.
- R10: `irq` is high exactly when some enabled source is pending, which is also exactly when the code is not 0x1.
- R11: After reset, all enables are off, FIFO mode is off, the selector is 0, `ident_byte` is 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| char_tick | input | 1 | One character time has elapsed |
| line_err | input | LERR_W | Held line error flags (overrun, parity, framing, break) |
| thr_empty | input | 1 | Transmit holding register is empty |
| tx_write | input | 1 | New transmit data written |
| iid_rd | input | 1 | Identification byte is being read |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 3 | Enable register write data |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_fifo_en | input | 1 | FIFO-mode enable write data |
| fcr_trig | input | 2 | Trigger selector write data |
| iid_code | output | 4 | Reported identification code |
| ident_byte | output | 8 | Identification readback byte |
| irq | output | 1 | Interrupt request |
| fifo_mode | output | 1 | FIFO mode is enabled |

## Verification
The bench builds two copies of the block. The main copy uses a depth of 16 and is compared cycle by cycle against a behavioural model, through directed steps and a long random phase. Together these reach every priority pairing, the full timeout count, and each way the transmit-empty source can be cleared. A second copy uses a depth of 64 and shares the register strobes. It is swept across all four selector values at one below and exactly at each threshold, so the deeper table is checked at its edges.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE  = 4'h1,
    ID_THRE  = 4'h2,
    ID_RDA   = 4'h4,
    ID_LSTAT = 4'h6,
    ID_CTO   = 4'hC
  } iid_e;

  // Threshold in characters for a given FIFO depth and trigger selector.
  function automatic int unsigned trig_level(input int unsigned depth,
                                             input logic [1:0] sel);
    int unsigned lvl;
    if (depth >= 64) begin
      case (sel)
        2'd0: lvl = 1;
        2'd1: lvl = 16;
        2'd2: lvl = 48;
        default: lvl = 56;
      endcase
    end else begin
      case (sel)
        2'd0: lvl = 1;
        2'd1: lvl = 4;
        2'd2: lvl = 8;
        default: lvl = 14;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             fifo_on,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] count,
  output logic             data_ready
);

  logic [CNT_W-1:0] level;

  always_comb begin
    if (fifo_on) level = CNT_W'(trig_level(DEPTH, sel));
    else         level = CNT_W'(1);
  end

  assign data_ready = (count >= level);

endmodule

// File: rtl/uart_char_timeout.sv
module uart_char_timeout #(
  parameter int unsigned CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic occupied,
  input  logic arrive,
  input  logic drain,
  input  logic tick,
  output logic expired
);

  localparam int unsigned TW = $clog2(CHARS + 1);
  localparam logic [TW-1:0] LIMIT = TW'(CHARS);

  logic [TW-1:0] cnt_q;
  logic          restart;

  assign restart = !enable || !occupied || arrive || drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart)                 cnt_q <= '0;
    else if (tick && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIMIT) && enable && occupied;

endmodule

// File: rtl/uart_thre_tracker.sv
module uart_thre_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic clr,
  output logic pend
);

  logic prev_q;
  logic rise;

  assign rise = thr_empty && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= thr_empty;
      if (clr)       pend <= 1'b0;
      else if (rise) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       ls,
  input  logic       rda,
  input  logic       cto,
  input  logic       thre,
  output logic [3:0] code,
  output logic       req
);

  iid_e sel_id;

  always_comb begin
    if (ls)        sel_id = ID_LSTAT;
    else if (rda)  sel_id = ID_RDA;
    else if (cto)  sel_id = ID_CTO;
    else if (thre) sel_id = ID_THRE;
    else           sel_id = ID_NONE;
  end

  assign code = sel_id;
  assign req  = ls | rda | cto | thre;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int unsigned TIMEOUT_CHARS = 4,
  parameter int unsigned LERR_W        = 4,
  localparam int unsigned CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              char_tick,
  input  logic [LERR_W-1:0] line_err,
  input  logic              thr_empty,
  input  logic              tx_write,
  input  logic              iid_rd,
  input  logic              ier_we,
  input  logic [2:0]        ier_wdata,
  input  logic              fcr_we,
  input  logic              fcr_fifo_en,
  input  logic [1:0]        fcr_trig,
  output logic [3:0]        iid_code,
  output logic [7:0]        ident_byte,
  output logic              irq,
  output logic              fifo_mode
);

  logic [2:0] ier_q;
  logic       fifo_q;
  logic [1:0] trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= '0;
      fifo_q <= 1'b0;
      trig_q <= '0;
    end else begin
      if (ier_we) ier_q <= ier_wdata;
      if (fcr_we) begin
        fifo_q <= fcr_fifo_en;
        trig_q <= fcr_trig;
      end
    end
  end

  // Named raw events, before enable masking.
  logic ls_raw, rda_raw, cto_raw, thre_raw;
  logic thre_clr;

  assign ls_raw = |line_err;

  uart_rx_trigger #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_trig (
    .fifo_on    (fifo_q),
    .sel        (trig_q),
    .count      (rx_count),
    .data_ready (rda_raw)
  );

  uart_char_timeout #(.CHARS(TIMEOUT_CHARS)) u_cto (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (fifo_q),
    .occupied (rx_count != '0),
    .arrive   (rx_push),
    .drain    (rx_pop),
    .tick     (char_tick),
    .expired  (cto_raw)
  );

  assign thre_clr = tx_write || (iid_rd && iid_code == ID_THRE);

  uart_thre_tracker u_thre (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_empty (thr_empty),
    .clr       (thre_clr),
    .pend      (thre_raw)
  );

  uart_irq_prio u_prio (
    .ls   (ls_raw   && ier_q[2]),
    .rda  (rda_raw  && ier_q[0]),
    .cto  (cto_raw  && ier_q[0]),
    .thre (thre_raw && ier_q[1]),
    .code (iid_code),
    .req  (irq)
  );

  assign fifo_mode  = fifo_q;
  assign ident_byte = {fifo_q, 3'b000, iid_code};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       ier,
  input logic             ls_any,
  input logic             rda_raw,
  input logic             cto_raw,
  input logic             thre_raw,
  input logic             rx_pop,
  input logic             tx_write,
  input logic [CNT_W-1:0] rx_count,
  input logic [3:0]       code,
  input logic [7:0]       ident_byte,
  input logic             irq,
  input logic             fifo_mode
);

  // R10
  irq_code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != 4'h1));

  // R3
  lstat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && ls_any) |-> code == 4'h6);

  // R8
  cto_pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !cto_raw);

  // R9
  thre_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> !thre_raw);

  // R6
  fifo_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident_byte[7] == fifo_mode);

  // R7
  rda_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rda_raw |-> rx_count != '0);

  // R2
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 3'b000) |-> !irq);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ier        (ier_q),
  .ls_any     (ls_raw),
  .rda_raw    (rda_raw),
  .cto_raw    (cto_raw),
  .thre_raw   (thre_raw),
  .rx_pop     (rx_pop),
  .tx_write   (tx_write),
  .rx_count   (rx_count),
  .code       (iid_code),
  .ident_byte (ident_byte),
  .irq        (irq),
  .fifo_mode  (fifo_mode)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] rx_count = '0;
  logic [6:0] rx_count64 = '0;
  logic rx_push = 0, rx_pop = 0, char_tick = 0, thr_empty = 0, tx_write = 0, iid_rd = 0;
  logic [3:0] line_err = '0;
  logic ier_we = 0, fcr_we = 0, fcr_fifo_en = 0;
  logic [2:0] ier_wdata = '0;
  logic [1:0] fcr_trig = '0;

  logic [3:0] code0, code1;
  logic [7:0] idb0, idb1;
  logic irq0, irq1, fm0, fm1;

  uart_irq_ident #(.FIFO_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .line_err(line_err), .thr_empty(thr_empty), .tx_write(tx_write),
    .iid_rd(iid_rd), .ier_we(ier_we), .ier_wdata(ier_wdata), .fcr_we(fcr_we),
    .fcr_fifo_en(fcr_fifo_en), .fcr_trig(fcr_trig), .iid_code(code0), .ident_byte(idb0),
    .irq(irq0), .fifo_mode(fm0));

  uart_irq_ident #(.FIFO_DEPTH(64)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count64), .rx_push(1'b0), .rx_pop(1'b0),
    .char_tick(1'b0), .line_err(4'b0000), .thr_empty(1'b0), .tx_write(1'b0),
    .iid_rd(1'b0), .ier_we(ier_we), .ier_wdata(ier_wdata), .fcr_we(fcr_we),
    .fcr_fifo_en(fcr_fifo_en), .fcr_trig(fcr_trig), .iid_code(code1), .ident_byte(idb1),
    .irq(irq1), .fifo_mode(fm1));

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model for u0 ----------------
  bit [2:0] m_ier;
  bit m_fifo;
  int m_sel;
  bit m_prev;
  bit m_thre;
  int m_to;

  function automatic int thr_of(int depth, int sel, bit fifo);
    int t16[4] = '{1, 4, 8, 14};
    int t64[4] = '{1, 16, 48, 56};
    if (!fifo) return 1;
    return (depth == 64) ? t64[sel] : t16[sel];
  endfunction

  function automatic logic [3:0] m_code();
    bit ls, rda, cto, th;
    ls  = (line_err != 0) && m_ier[2];
    rda = m_ier[0] && (int'(rx_count) >= thr_of(16, m_sel, m_fifo));
    cto = m_ier[0] && m_fifo && (rx_count != 0) && (m_to == 4);
    th  = m_ier[1] && m_thre;
    if (ls) return 4'h6;
    if (rda) return 4'h4;
    if (cto) return 4'hC;
    if (th) return 4'h2;
    return 4'h1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ier = 0; m_fifo = 0; m_sel = 0; m_prev = 0; m_thre = 0; m_to = 0;
    end else begin
      logic [3:0] c;
      c = m_code();
      if (tx_write || (iid_rd && c == 4'h2)) m_thre = 0;
      else if (thr_empty && !m_prev) m_thre = 1;
      m_prev = thr_empty;
      if (!m_fifo || rx_count == 0 || rx_push || rx_pop) m_to = 0;
      else if (char_tick && m_to < 4) m_to++;
      if (ier_we) m_ier = ier_wdata;
      if (fcr_we) begin m_fifo = fcr_fifo_en; m_sel = int'(fcr_trig); end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic [3:0] c;
      c = m_code();
      chk("R1 R3 model code", idb0, {m_fifo, 3'b000, c});
      chk("R10 model irq", {7'd0, irq0}, {7'd0, c != 4'h1});
      chk("R6 model fifo_mode", {7'd0, fm0}, {7'd0, m_fifo});
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=expired exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drv();
    @(negedge clk); #2;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic wr_ier(input logic [2:0] v);
    drv(); ier_we = 1; ier_wdata = v;
    drv(); ier_we = 0;
  endtask

  task automatic wr_fcr(input logic en, input logic [1:0] t);
    drv(); fcr_we = 1; fcr_fifo_en = en; fcr_trig = t;
    drv(); fcr_we = 0;
  endtask

  initial begin
    int t16[4] = '{1, 4, 8, 14};
    int t64[4] = '{1, 16, 48, 56};
    repeat (3) @(negedge clk);
    // R11 reset values, still in reset
    chk("R11 reset ident", idb0, 8'h01);
    chk("R11 reset irq", {7'd0, irq0}, 8'h00);
    #2 rst_n = 1;
    cmp_on = 1;
    smp();
    chk("R11 after release", idb0, 8'h01);

    // enables on, FIFO on with selector 2, THR becomes empty
    drv(); ier_we = 1; ier_wdata = 3'b111; fcr_we = 1; fcr_fifo_en = 1; fcr_trig = 2; thr_empty = 1;
    drv(); ier_we = 0; fcr_we = 0;
    smp();
    chk("R9 thre set on rise", idb0, 8'h82);
    chk("R6 fifo bit", {7'd0, fm0}, 8'h01);
    drv(); tx_write = 1;
    drv(); tx_write = 0;
    smp();
    chk("R9 thre cleared by write", idb0, 8'h81);

    // data ready around threshold 8
    drv(); rx_count = 7; smp();
    chk("R4 below threshold", idb0, 8'h81);
    drv(); rx_count = 8; smp();
    chk("R7 at threshold", idb0, 8'h84);
    drv(); line_err = 4'b0010; smp();
    chk("R3 line status over data", idb0, 8'h86);
    chk("R1 line status code", {4'h0, code0}, 8'h06);
    drv(); line_err = 0; rx_count = 7; smp();
    chk("R7 drops below", idb0, 8'h81);

    // character timeout
    drv(); rx_count = 3; char_tick = 1;
    repeat (3) @(negedge clk);
    chk("R8 three ticks", idb0, 8'h81);
    @(negedge clk);
    chk("R8 four ticks", idb0, 8'h8C);
    drv(); char_tick = 0; rx_pop = 1;
    drv(); rx_pop = 0; smp();
    chk("R8 cleared by read", idb0, 8'h81);
    drv(); char_tick = 1;
    repeat (2) @(negedge clk);
    #2 rx_push = 1;
    drv(); rx_push = 0;
    repeat (2) @(negedge clk);
    chk("R8 arrival restarts", idb0, 8'h81);
    drv(); char_tick = 0; rx_count = 0;

    // THRE vs data ready, read clearing
    drv(); thr_empty = 0;
    drv(); thr_empty = 1; rx_count = 8;
    smp();
    chk("R3 data over thre", idb0, 8'h84);
    drv(); iid_rd = 1;
    drv(); iid_rd = 0; rx_count = 0; smp();
    chk("R9 read while other reported keeps thre", idb0, 8'h82);
    drv(); iid_rd = 1;
    drv(); iid_rd = 0; smp();
    chk("R9 read clears thre", idb0, 8'h81);

    // threshold tables, both depths
    wr_ier(3'b001);
    for (int s = 0; s < 4; s++) begin
      wr_fcr(1'b1, 2'(s));
      drv(); rx_count = 5'(t16[s] - 1); rx_count64 = 7'(t64[s] - 1); smp();
      chk("R4 depth16 below", idb0, 8'h81);
      chk("R5 depth64 below", idb1, 8'h81);
      drv(); rx_count = 5'(t16[s]); rx_count64 = 7'(t64[s]); smp();
      chk("R4 depth16 at", idb0, 8'h84);
      chk("R5 depth64 at", idb1, 8'h84);
    end

    // enable masking
    drv(); rx_count = 14; line_err = 4'b0001;
    wr_ier(3'b010); smp();
    chk("R2 masked ident", idb0, 8'h81);
    chk("R2 masked irq", {7'd0, irq0}, 8'h00);
    wr_ier(3'b001); smp();
    chk("R2 data enable only", idb0, 8'h84);
    chk("R10 irq raised", {7'd0, irq0}, 8'h01);
    drv(); line_err = 0;

    // FIFO off: threshold 1, bit 7 low
    wr_fcr(1'b0, 2'd3);
    drv(); rx_count = 1; smp();
    chk("R6 non-fifo threshold one", idb0, 8'h04);
    drv(); rx_count = 0;

    // random phase, model comparison every cycle
    for (int i = 0; i < 4000; i++) begin
      drv();
      rx_push = ($urandom_range(15) == 0);
      rx_pop = ($urandom_range(15) == 0);
      char_tick = ($urandom_range(1) == 0);
      iid_rd = ($urandom_range(3) == 0);
      tx_write = ($urandom_range(15) == 0);
      if ($urandom_range(7) == 0) thr_empty = ~thr_empty;
      if ($urandom_range(31) == 0) rx_count = 5'($urandom_range(16));
      line_err = ($urandom_range(15) == 0) ? 4'($urandom_range(15)) : 4'h0;
      ier_we = ($urandom_range(63) == 0);
      ier_wdata = 3'($urandom_range(7));
      fcr_we = ($urandom_range(63) == 0);
      fcr_fifo_en = ($urandom_range(3) != 0);
      fcr_trig = 2'($urandom_range(3));
    end
    drv();
    rx_push = 0; rx_pop = 0; char_tick = 0; iid_rd = 0; tx_write = 0;
    ier_we = 0; fcr_we = 0; line_err = 0;
    smp();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule